// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Admission

This block keeps the return addresses of a small processor core in a fixed number of hardware slots. A subroutine call, or the acknowledgment of an interrupt, saves the current program-counter value. A return, or a return from interrupt, takes the most recent saved value back off the stack. The restored value is always visible on an output, so the core can load it in the cycle it issues the pop. Software cannot read or write the slots or the pointer.

The block also decides when an interrupt may be taken. An incoming request is latched first. It is acknowledged only in a cycle where the stack has a free slot and no call or return is in progress. When the stack is full the request stays pending. It is taken as soon as a return has freed a slot. A call made at full depth is never blocked: it replaces the oldest saved address, so the stack always holds the most recent return addresses.

Top module: `return_stack_gate`

## Requirements
- R1: After reset no slot is occupied, `full_o` is 0, `irq_ack_o` is 0 and `pc_o` reads 0.
- R2: A push stores `pc_i` at the rising edge. From the next cycle on, `pc_o` shows the most recently stored value that has not been popped, so pops return the values in last-in, first-out order.
- R3: `full_o` is 1 exactly while `DEPTH` (default 8) values are held.
- R4: A push while full replaces the oldest value and `full_o` stays 1. The `DEPTH` pops that follow return the `DEPTH` most recent values, newest first.
- R5: A pop while empty changes nothing: `pc_o` keeps its value and `full_o` stays 0.
- R6: A 1 on `irq_i` at a rising edge latches a pending request. `irq_ack_o` is 1 in a cycle where a request is pending, the stack is not full, and neither `push_i` nor `pop_i` is 1. In that cycle `pc_i` is pushed at the edge.
- R7: While the stack is full, `irq_ack_o` stays 0 and the request stays pending. After a pop frees a slot, the request is acknowledged in the next cycle that has no push or pop.
- R8: An acknowledged request is cleared, so a single request produces a single acknowledgment.
- R9: `irq_ack_o` is 0 in any cycle where `push_i` or `pop_i` is 1, even when a request is pending and a slot is free.
- R10: `push_i` and `pop_i` together replace the top value with `pc_i` and leave the occupancy unchanged. On an empty stack they act as a plain push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save `pc_i` (subroutine call) |
| pop_i | input | 1 | Restore the top value (return or return from interrupt) |
| irq_i | input | 1 | Unmasked interrupt request, latched at the edge |
| pc_i | input | PC_W | Program-counter value to save |
| pc_o | output | PC_W | Value that the next pop restores |
| irq_ack_o | output | 1 | Interrupt taken this cycle; `pc_i` is saved at the edge |
| full_o | output | 1 | All slots are occupied |

## Verification
The bench builds the block with its defaults: `DEPTH` of 8 and a 13-bit program counter. With these values the full state is reached after eight calls and overflow after nine, so the bench can drive wrap-around of the slot pointer, loss of the oldest addresses and a complete unwind within a few dozen cycles. The small depth also keeps a withheld interrupt close to a return, so the bench reaches both its blocking at full depth and its release one cycle after a pop.

// File: rtl/rsk_pkg.sv
package rsk_pkg;

    // Stack operation chosen for one cycle
    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

endpackage

// File: rtl/rsk_store.sv
module rsk_store #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 13,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [PC_W-1:0] wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [PC_W-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] slot;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_idx == IW'(i))) begin
                st_d.slot[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.slot[rd_idx];

    // Written slot holds the written value one cycle later
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.slot[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/rsk_ptr.sv
module rsk_ptr #(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  rsk_pkg::stk_op_e       op,
    output logic                   wr_en,
    output logic [IW-1:0]          wr_idx,
    output logic [IW-1:0]          top_idx,
    output logic                   full
);
    import rsk_pkg::*;

    localparam logic [IW-1:0] LAST  = IW'(DEPTH - 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    typedef struct packed {
        logic [IW-1:0] ptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t pt_d, pt_q;
    logic [IW-1:0] ptr_inc, ptr_dec;

    assign ptr_inc = (pt_q.ptr == LAST) ? '0 : pt_q.ptr + 1'b1;
    assign ptr_dec = (pt_q.ptr == '0) ? LAST : pt_q.ptr - 1'b1;

    always_comb begin
        pt_d   = pt_q;
        wr_en  = 1'b0;
        wr_idx = pt_q.ptr;
        unique case (op)
            STK_PUSH: begin
                wr_en   = 1'b1;
                pt_d.ptr = ptr_inc;
                if (pt_q.cnt != LIMIT) pt_d.cnt = pt_q.cnt + 1'b1;
            end
            STK_POP: begin
                if (pt_q.cnt != '0) begin
                    pt_d.ptr = ptr_dec;
                    pt_d.cnt = pt_q.cnt - 1'b1;
                end
            end
            STK_SWAP: begin
                wr_en = 1'b1;
                if (pt_q.cnt != '0) begin
                    wr_idx = ptr_dec;
                end else begin
                    pt_d.ptr = ptr_inc;
                    pt_d.cnt = pt_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign top_idx = ptr_dec;
    assign full    = (pt_q.cnt == LIMIT);

    assert_count_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pt_q.cnt <= LIMIT);

    assert_overflow_stays_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH && full) |=> full);

    assert_empty_pop_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_POP && pt_q.cnt == '0) |=> (pt_q.cnt == '0 && $stable(pt_q.ptr)));

    assert_swap_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_SWAP && pt_q.cnt != '0) |=> $stable(pt_q.cnt));

endmodule

// File: rtl/rsk_irq_gate.sv
module rsk_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic full_i,
    input  logic busy_i,
    output logic ack_o
);

    typedef struct packed {
        logic pend;
    } gate_t;

    gate_t gt_d, gt_q;

    always_comb begin
        ack_o       = gt_q.pend && !full_i && !busy_i;
        gt_d.pend   = (gt_q.pend && !ack_o) || irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gt_q <= '0;
        end else begin
            gt_q <= gt_d;
        end
    end

    assert_request_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> gt_q.pend);

    assert_ack_blocked_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !full_i);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !irq_i) |=> !gt_q.pend);

    assert_ack_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !busy_i);

endmodule

// File: rtl/return_stack_gate.sv
module return_stack_gate #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic            irq_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc_o,
    output logic            irq_ack_o,
    output logic            full_o
);
    import rsk_pkg::*;

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stk_op_e       op;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] top_idx;
    logic          full;
    logic          ack;

    always_comb begin
        if (push_i && pop_i)     op = STK_SWAP;
        else if (push_i || ack)  op = STK_PUSH;
        else if (pop_i)          op = STK_POP;
        else                     op = STK_IDLE;
    end

    rsk_irq_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .full_i (full),
        .busy_i (push_i || pop_i),
        .ack_o  (ack)
    );

    rsk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .top_idx (top_idx),
        .full    (full)
    );

    rsk_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (pc_i),
        .rd_idx  (top_idx),
        .rd_data (pc_o)
    );

    assign irq_ack_o = ack;
    assign full_o    = full;

    // An acknowledged interrupt saves pc_i: it is on top next cycle
    assert_ack_saves_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> pc_o == $past(pc_i));

endmodule

// File: tb/test_return_stack_gate.sv
module test_return_stack_gate;

    localparam int DEPTH = 8;
    localparam int PC_W  = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push_i = 1'b0, pop_i = 1'b0, irq_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic [PC_W-1:0] pc_o;
    logic            irq_ack_o, full_o;

    always #4 clk = ~clk;

    return_stack_gate #(.DEPTH(DEPTH), .PC_W(PC_W)) i_return_stack_gate (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .irq_i(irq_i),
        .pc_i(pc_i), .pc_o(pc_o), .irq_ack_o(irq_ack_o), .full_o(full_o)
    );

    typedef struct {
        string           tag;
        bit              exp_full;
        bit              has_pc;
        logic [PC_W-1:0] exp_pc;
    } exp_t;

    exp_t            sb[$];
    logic [PC_W-1:0] model[$];
    bit              pend_m = 1'b0;
    int              n_chk = 0, n_fail = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: called 1 ns after a rising edge, drives one cycle
    task automatic op(bit pu, bit po, bit ir, logic [PC_W-1:0] pc, string tag);
        bit   ack_m;
        exp_t r;
        push_i = pu; pop_i = po; irq_i = ir; pc_i = pc;
        #2;
        ack_m = pend_m && (model.size() < DEPTH) && !pu && !po;
        chk({tag, " ack"}, 32'(irq_ack_o), 32'(ack_m));
        @(posedge clk);
        if (pu && po) begin
            if (model.size() > 0) model[$] = pc;
            else model.push_back(pc);
        end else if (pu || ack_m) begin
            if (model.size() == DEPTH) void'(model.pop_front());
            model.push_back(pc);
        end else if (po) begin
            if (model.size() > 0) void'(model.pop_back());
        end
        pend_m = (pend_m && !ack_m) || ir;
        r.tag      = tag;
        r.exp_full = (model.size() == DEPTH);
        r.has_pc   = (model.size() > 0);
        r.exp_pc   = r.has_pc ? model[$] : '0;
        sb.push_back(r);
        #1;
        push_i = 0; pop_i = 0; irq_i = 0; pc_i = '0;
    endtask

    // Monitor: compares registered outputs away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t r;
                r = sb.pop_front();
                chk({r.tag, " full"}, 32'(full_o), 32'(r.exp_full));
                if (r.has_pc) chk({r.tag, " pc"}, 32'(pc_o), 32'(r.exp_pc));
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", 32'(pc_o), 0);
        chk("R1 reset full", 32'(full_o), 0);
        chk("R1 reset ack", 32'(irq_ack_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R2: LIFO order
        op(1, 0, 0, 13'h0A1, "R2 push");
        op(1, 0, 0, 13'h0B2, "R2 push");
        op(1, 0, 0, 13'h0C3, "R2 push");
        op(0, 1, 0, 13'h0,   "R2 pop");
        op(0, 1, 0, 13'h0,   "R2 pop");
        op(0, 1, 0, 13'h0,   "R2 pop");

        // R3 fill, R4 overflow and unwind
        for (int i = 0; i < DEPTH; i++) op(1, 0, 0, 13'(16'h100 + i), "R3 fill");
        op(1, 0, 0, 13'h1E0, "R4 overflow");
        op(1, 0, 0, 13'h1E1, "R4 overflow");
        for (int i = 0; i < DEPTH; i++) op(0, 1, 0, 13'h0, "R4 unwind");

        // R5: pop on empty changes nothing
        @(negedge clk); held = pc_o;
        @(posedge clk); #1;
        op(0, 1, 0, 13'h0, "R5 empty pop");
        @(negedge clk);
        chk("R5 pc held", 32'(pc_o), 32'(held));
        chk("R5 not full", 32'(full_o), 0);
        @(posedge clk); #1;
        op(1, 0, 0, 13'h055, "R5 push after");
        op(0, 1, 0, 13'h0,   "R5 pop after");

        // R10: push with pop
        op(1, 1, 0, 13'h0D1, "R10 swap empty");
        op(1, 0, 0, 13'h0D2, "R10 push");
        op(1, 1, 0, 13'h0D3, "R10 swap");
        op(0, 1, 0, 13'h0,   "R10 pop");
        op(0, 1, 0, 13'h0,   "R10 pop");

        // R6, R8: latch then acknowledge once
        op(0, 0, 1, 13'h0,   "R6 raise");
        op(0, 0, 0, 13'h111, "R6 take");
        op(0, 0, 0, 13'h0,   "R8 no repeat");
        op(0, 1, 0, 13'h0,   "R6 return");

        // R9: busy cycles withhold acknowledgment
        op(0, 0, 1, 13'h0,   "R9 raise");
        op(1, 0, 0, 13'h0E1, "R9 push busy");
        op(0, 1, 0, 13'h0,   "R9 pop busy");
        op(0, 0, 0, 13'h122, "R9 take");
        op(0, 1, 0, 13'h0,   "R9 return");

        // R7: full blocks, a return releases
        for (int i = 0; i < DEPTH; i++) op(1, 0, 0, 13'(16'h200 + i), "R7 fill");
        op(0, 0, 1, 13'h0,   "R7 raise");
        op(0, 0, 0, 13'h333, "R7 held");
        op(0, 0, 0, 13'h333, "R7 held");
        op(0, 1, 0, 13'h0,   "R7 return");
        op(0, 0, 0, 13'h344, "R7 take");
        op(0, 0, 0, 13'h0,   "R7 after");
        for (int i = 0; i < DEPTH; i++) op(0, 1, 0, 13'h0, "R7 unwind");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule